// File: doc/BRIEF.md
# Chained Descriptor DMA Sequencer

This block is a single DMA channel that works through a linked list of segment descriptors kept in word-addressed memory. Software loads a pointer to the first descriptor and pulses a start input. The channel then fetches four words from that descriptor: source address, destination address, a link word and a byte count. It copies the segment one word at a time, with a read followed by a write, and follows the link to the next descriptor. The walk ends after a descriptor that carries the end-of-chain mark.

Descriptors sit on 32-byte boundaries. The link word therefore carries the next descriptor's address in its upper bits and five control bits in its low bits. These bits belong to the descriptor that holds them. They mark the end of the chain, ask for an interrupt when the segment ends, and tag the segment's memory traffic with a coherency (snoop) attribute. Two of them are reserved.

The memory port returns read data one cycle after the cycle in which the read request is visible. Writes take effect at the clock edge that ends the cycle in which the write request is visible.

Top module: `dma_chain_seq`

## Requirements
- R1: When idle, a start pulse with a start pointer whose bits 4..0 are zero begins the walk. The block issues reads of the descriptor words at offsets 0x00 (source), 0x04 (destination), 0x08 (link word) and 0x0C (byte count). It never reads offsets 0x10..0x1F. `busy` is high from the cycle after the start edge until the walk ends, and no memory request is issued while `busy` is low.
- R2: A segment with byte count N (a multiple of 4) produces N/4 writes. The k-th write, counting from 0, goes to destination+4k and carries the word read from source+4k. Writes come in increasing address order.
- R3: If link-word bit 0 (end of chain) is set, the block completes that segment and stops without reading any word at the linked address. It then sets `done`, and `done` stays high while the block is idle.
- R4: If link-word bit 0 is clear, the next descriptor is fetched from the link word with bits 4..0 forced to zero.
- R5: If link-word bit 3 is set, `seg_irq` is high for exactly one cycle after that segment's last write, or after its fetch when the count is zero. There is no pulse when bit 3 is clear.
- R6: If link-word bit 4 is set, `mem_snoop` is high with every data read and write of that segment, and `mem_snoop` is never high without a memory request.
- R7: A byte count of zero moves no data, and the walk continues by the rules of R3 and R4.
- R8: A start pointer with any of bits 4..0 nonzero sets `desc_err`. No memory request is issued and `busy` stays low.
- R9: A fetched link word with bit 1 or bit 2 (reserved) set sets `desc_err` and stops the walk. No data of that descriptor is moved, and `done` is not set.
- R10: An accepted start clears `done` and `desc_err`.
- R11: A start pulse while `busy` is high is ignored.
- R12: After reset, `busy`, `done`, `desc_err`, `seg_irq`, `mem_rd_en`, `mem_wr_en` and `mem_snoop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cur_desc_ptr | input | AW | Byte address of the first descriptor |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Byte address of the read |
| mem_rd_data | input | DW | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Byte address of the write |
| mem_wr_data | output | DW | Write data |
| mem_snoop | output | 1 | Snoop attribute for the current data request |
| busy | output | 1 | Channel is walking a chain |
| done | output | 1 | Sticky: the chain ended normally |
| desc_err | output | 1 | Sticky: misaligned start pointer or reserved bits set |
| seg_irq | output | 1 | One-cycle end-of-segment interrupt |

## Verification
A wrong internal state shows up at the memory port within a few cycles. If the fetch capture picks the wrong word slot, the very first data write has the wrong address or data, so the scoreboard catches the problem at the first write. If the word counter is off by one, a segment has an extra write or is missing its last one. An extra write is flagged when it appears, and a missing write is flagged at the end of the chain. If the chain-end or link decoding is wrong, the block either reads the poisoned region placed behind the last descriptor, gets `done` or the interrupt count wrong, or misses the reserved-bit error before any write of that descriptor.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_READ, S_RWAIT, S_WRITE, S_SEGEND, S_DONE
  } seq_state_t;

  localparam int CTRL_BITS  = 5;
  localparam int EOT_BIT    = 0;
  localparam int RSV_LO_BIT = 1;
  localparam int RSV_HI_BIT = 2;
  localparam int IRQ_BIT    = 3;
  localparam int SNP_BIT    = 4;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [DW-1:0]    cap_data,
  input  logic             adv_en,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [DW-1:0]    link_q,
  output logic [DW-1:0]    cnt_q
);
  localparam int STEP = DW / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      link_q <= '0;
      cnt_q  <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        2'd0:    src_q  <= cap_data[AW-1:0];
        2'd1:    dst_q  <= cap_data[AW-1:0];
        2'd2:    link_q <= cap_data;
        default: cnt_q  <= cap_data;
      endcase
    end else if (adv_en) begin
      src_q <= src_q + AW'(STEP);
      dst_q <= dst_q + AW'(STEP);
      cnt_q <= cnt_q - DW'(STEP);
    end
  end

  // R7: the sequencer never steps a segment whose count is already used up
  p_adv_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    adv_en |-> (cnt_q != '0));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    cur_ptr,
  input  logic [DW-1:0]    rd_data,
  input  logic [AW-1:0]    src_q,
  input  logic [AW-1:0]    dst_q,
  input  logic [DW-1:0]    link_q,
  input  logic [DW-1:0]    cnt_q,
  output logic             rd_en_q,
  output logic [AW-1:0]    rd_addr_q,
  output logic             wr_en_q,
  output logic [AW-1:0]    wr_addr_q,
  output logic [DW-1:0]    wr_data_q,
  output logic             snoop_q,
  output logic             busy,
  output logic             done_q,
  output logic             err_q,
  output logic             irq_q,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             adv_en
);
  localparam int STEP    = DW / 8;
  localparam int STEP_SH = $clog2(STEP);
  localparam int ISS_W   = IDX_W + 1;

  seq_state_t       state_q;
  logic [AW-1:0]    ptr_q;
  logic [ISS_W-1:0] iss_q;
  logic [IDX_W-1:0] rtag_q;
  logic             pend_q;
  logic [IDX_W-1:0] ptag_q;
  logic             last_cap;

  assign busy     = (state_q != S_IDLE);
  assign cap_en   = (state_q == S_FETCH) && pend_q;
  assign cap_idx  = ptag_q;
  assign adv_en   = (state_q == S_WRITE);
  assign last_cap = cap_en && (ptag_q == IDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ptr_q     <= '0;
      iss_q     <= '0;
      rtag_q    <= '0;
      pend_q    <= 1'b0;
      ptag_q    <= '0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      snoop_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      snoop_q <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= rd_en_q && (state_q == S_FETCH);
      ptag_q  <= rtag_q;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            done_q <= 1'b0;
            if (cur_ptr[CTRL_BITS-1:0] != '0) begin
              err_q <= 1'b1;
            end else begin
              err_q   <= 1'b0;
              ptr_q   <= cur_ptr;
              iss_q   <= '0;
              state_q <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (iss_q < ISS_W'(DESC_WORDS)) begin
            rd_en_q   <= 1'b1;
            rd_addr_q <= ptr_q + (AW'(iss_q) << STEP_SH);
            rtag_q    <= iss_q[IDX_W-1:0];
            iss_q     <= iss_q + 1'b1;
          end
          if (last_cap) state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (link_q[RSV_HI_BIT:RSV_LO_BIT] != '0) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= S_SEGEND;
          end else begin
            state_q <= S_READ;
          end
        end
        S_READ: begin
          rd_en_q   <= 1'b1;
          rd_addr_q <= src_q;
          snoop_q   <= link_q[SNP_BIT];
          state_q   <= S_RWAIT;
        end
        S_RWAIT: state_q <= S_WRITE;
        S_WRITE: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= dst_q;
          wr_data_q <= rd_data;
          snoop_q   <= link_q[SNP_BIT];
          state_q   <= (cnt_q <= DW'(STEP)) ? S_SEGEND : S_READ;
        end
        S_SEGEND: begin
          irq_q <= link_q[IRQ_BIT];
          if (link_q[EOT_BIT]) begin
            state_q <= S_DONE;
          end else begin
            ptr_q   <= {link_q[AW-1:CTRL_BITS], {CTRL_BITS{1'b0}}};
            iss_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        S_DONE: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: no memory traffic while idle
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_en_q && !wr_en_q));
  // R1: descriptor reads stay inside the first 16 bytes of the descriptor
  p_fetch_window_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en_q && state_q == S_FETCH) |->
      (rd_addr_q[AW-1:4] == ptr_q[AW-1:4] && !rd_addr_q[4]));
  // R2: every data write is preceded by its read two cycles earlier
  p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> $past(rd_en_q, 2));
  // R3: done only stands while idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy);
  // R5: interrupt is a single-cycle pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R6: snoop attribute only accompanies a request
  p_snoop_req_r6: assert property (@(posedge clk) disable iff (rst)
    snoop_q |-> (rd_en_q || wr_en_q));
  // R8: an error leaves the channel stopped
  p_err_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] cur_desc_ptr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_snoop,
  output logic          busy,
  output logic          done,
  output logic          desc_err,
  output logic          seg_irq
);
  logic             cap_en;
  logic [IDX_W-1:0] cap_idx;
  logic             adv_en;
  logic [AW-1:0]    src_q;
  logic [AW-1:0]    dst_q;
  logic [DW-1:0]    link_q;
  logic [DW-1:0]    cnt_q;

  dma_desc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (mem_rd_data),
    .adv_en   (adv_en),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .link_q   (link_q),
    .cnt_q    (cnt_q)
  );

  dma_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cur_ptr   (cur_desc_ptr),
    .rd_data   (mem_rd_data),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .link_q    (link_q),
    .cnt_q     (cnt_q),
    .rd_en_q   (mem_rd_en),
    .rd_addr_q (mem_rd_addr),
    .wr_en_q   (mem_wr_en),
    .wr_addr_q (mem_wr_addr),
    .wr_data_q (mem_wr_data),
    .snoop_q   (mem_snoop),
    .busy      (busy),
    .done_q    (done),
    .err_q     (desc_err),
    .irq_q     (seg_irq),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .adv_en    (adv_en)
  );
endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] cur_desc_ptr = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_snoop;
  logic          busy, done, desc_err, seg_irq;

  dma_chain_seq #(.AW(AW), .DW(DW)) i_dma_chain_seq (
    .clk(clk), .rst(rst), .start(start), .cur_desc_ptr(cur_desc_ptr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_snoop(mem_snoop), .busy(busy), .done(done), .desc_err(desc_err),
    .seg_irq(seg_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
    if (mem_wr_en) mem[mem_wr_addr[9:2]] <= mem_wr_data;
  end

  typedef struct { logic [31:0] a; logic [31:0] d; logic s; } wr_item_t;
  wr_item_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int exp_irq = 0;
  int irq_seen = 0;
  int pad_reads = 0;
  int poison_reads = 0;
  int rd_total = 0;
  int cyc = 0;
  logic prev_irq = 1'b0;

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_desc(input int base, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] lnk,
                          input logic [31:0] cnt);
    mem[base/4]     = src;
    mem[base/4 + 1] = dst;
    mem[base/4 + 2] = lnk;
    mem[base/4 + 3] = cnt;
  endtask

  // driver side of the scoreboard: expected writes of one segment
  task automatic push_seg(input int base);
    logic [31:0] src, dst, lnk, cnt;
    wr_item_t it;
    src = mem[base/4];
    dst = mem[base/4 + 1];
    lnk = mem[base/4 + 2];
    cnt = mem[base/4 + 3];
    for (int k = 0; k < int'(cnt) / 4; k++) begin
      it.a = dst + 32'(4 * k);
      it.d = mem[src[9:2] + 8'(k)];
      it.s = lnk[4];
      exp_q.push_back(it);
    end
    if (lnk[3]) exp_irq++;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_en) begin
        if (exp_q.size() == 0) begin
          chk("R2", mem_wr_addr, 32'hFFFF_FFFF, "unexpected write address");
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          chk("R2", mem_wr_addr, it.a, "write address");
          chk("R2", mem_wr_data, it.d, "write data");
          chk("R6", {31'd0, mem_snoop}, {31'd0, it.s}, "snoop on write");
        end
      end
      if (mem_rd_en) begin
        rd_total++;
        if (mem_rd_addr < 32'h100 && mem_rd_addr[4]) pad_reads++;
        if (mem_rd_addr >= 32'hE0 && mem_rd_addr < 32'h100) poison_reads++;
      end
      if (seg_irq) begin
        irq_seen++;
        if (prev_irq) chk("R5", 32'd2, 32'd1, "irq pulse width");
      end
      prev_irq <= seg_irq;
    end
  end

  task automatic kick(input logic [31:0] ptr);
    @(negedge clk);
    cur_desc_ptr = ptr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int rd_before;
    for (int i = 0; i < 256; i++) mem[i] = {8'hA5, 8'(i), 16'(i * 37 + 5)};
    // chain A: 8 bytes irq, zero-count irq, 12 bytes snoop + end
    set_desc(32'h000, 32'h100, 32'h200, 32'h020 | 32'h08, 32'd8);
    set_desc(32'h020, 32'h140, 32'h240, 32'h040 | 32'h08, 32'd0);
    set_desc(32'h040, 32'h180, 32'h280, 32'h0E0 | 32'h10 | 32'h01, 32'd12);
    // chain B: 8 bytes irq+snoop, then reserved bit set
    set_desc(32'h080, 32'h1C0, 32'h2C0, 32'h0A0 | 32'h18, 32'd8);
    set_desc(32'h0A0, 32'h1E0, 32'h2E0, 32'h0C0 | 32'h02 | 32'h08, 32'd8);
    // chain C: single 16-byte segment, end
    set_desc(32'h0C0, 32'h100, 32'h300, 32'h0E0 | 32'h01, 32'd16);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", {28'd0, busy, done, desc_err, seg_irq}, 32'd0, "flags after reset");
    chk("R12", {29'd0, mem_rd_en, mem_wr_en, mem_snoop}, 32'd0, "requests after reset");

    // chain A
    push_seg(32'h000); push_seg(32'h020); push_seg(32'h040);
    kick(32'h000);
    chk("R1", {31'd0, busy}, 32'd1, "busy after start");
    wait_idle();
    chk("R3", {31'd0, done}, 32'd1, "done after chain end");
    chk("R3", {31'd0, busy}, 32'd0, "busy after chain end");
    chk("R9", {31'd0, desc_err}, 32'd0, "no error on clean chain");
    chk("R5", 32'(irq_seen), 32'(exp_irq), "irq count incl zero-count segment");
    chk("R7", 32'(exp_q.size()), 32'd0, "all writes seen (R4 link follow)");

    // misaligned start
    rd_before = rd_total;
    kick(32'h024);
    chk("R8", {31'd0, desc_err}, 32'd1, "misaligned start error");
    chk("R8", {31'd0, busy}, 32'd0, "misaligned start not busy");
    chk("R10", {31'd0, done}, 32'd0, "done cleared by start");
    repeat (20) @(negedge clk);
    chk("R8", 32'(rd_total - rd_before), 32'd0, "no reads after misaligned start");

    // chain B: reserved bits stop the walk
    irq_seen = 0; exp_irq = 0;
    push_seg(32'h080);
    kick(32'h080);
    chk("R10", {31'd0, desc_err}, 32'd0, "error cleared by start");
    wait_idle();
    chk("R9", {31'd0, desc_err}, 32'd1, "reserved bits error");
    chk("R9", {31'd0, done}, 32'd0, "no done on error");
    chk("R9", 32'(exp_q.size()), 32'd0, "first segment complete");
    chk("R5", 32'(irq_seen), 32'd1, "irq of first segment only");

    // chain C with start while busy
    irq_seen = 0; exp_irq = 0;
    push_seg(32'h0C0);
    kick(32'h0C0);
    repeat (3) @(negedge clk);
    start = 1'b1; cur_desc_ptr = 32'h000;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R11", {31'd0, done}, 32'd1, "done with start ignored");
    chk("R11", 32'(exp_q.size()), 32'd0, "only original chain written");
    chk("R5", 32'(irq_seen), 32'd0, "no irq without enable");
    repeat (20) @(negedge clk);
    chk("R11", {31'd0, busy}, 32'd0, "no second walk");

    chk("R1", 32'(pad_reads), 32'd0, "no reads of descriptor padding");
    chk("R3", 32'(poison_reads), 32'd0, "no fetch past chain end");
    chk("R2", mem[32'h30C >> 2], mem[32'h10C >> 2], "last word landed");
    finish_run();
  end
endmodule